// File: doc/BRIEF.md
# Sector Sync Protection Unit

This block keeps track of sector framing in a stream of disc data words. An upstream pattern matcher flags each word that carries a sync pattern. A position counter measures how many qualified words have arrived since the current sector began. A sync is legitimate only on the word that follows a full sector, which is the word seen while the counter sits at its terminal value `SECTOR_WORDS`. When framing holds, every sector start is reported as a one-cycle pulse together with a length class for the sector that just ended.

Syncs can turn up in the wrong place, and an expected sync can fail to appear. Two policies cover these cases. A misplaced sync is either discarded or used to restart framing. A missing sync is either replaced by an interpolated one or absorbed by stretching the sector. A stretched sector ends when a real sync arrives, or else it is cut off once it runs `MAX_OVR` words past nominal. Each irregular event raises a sticky interrupt and stores a cause code. Software clears both by pulsing the acknowledge input. The two policy inputs only take effect at sector boundaries.

Top module: `sector_sync_guard`

## Requirements
- R1: After reset, `sector_start`, `sector_class`, `irq` and `irq_cause` are all 0 and framing is unlocked. Before lock, words without a sync produce nothing. The first qualified sync starts a sector with class normal (0) and raises no interrupt.
- R2: Once locked, a sync on the word that arrives with the counter at `SECTOR_WORDS` starts a new sector with class normal (0) and raises no interrupt.
- R3: If `resync_mode` was 0 when the current sector began, a sync that arrives before the terminal position is discarded. No start is reported, counting carries on, and the interrupt is raised with cause 1.
- R4: If `resync_mode` was 1 when the current sector began, a sync that arrives before the terminal position starts a new sector with class short (1) and cause 3.
- R5: If `stretch_mode` was 0 when the current sector began, a word without a sync at the terminal position becomes an interpolated start with class normal (0) and cause 2.
- R6: If `stretch_mode` was 1 when the current sector began, a word without a sync at the terminal position reports no start and raises cause 4. A later real sync starts a new sector with class long (2) and raises no new event.
- R7: If a stretched sector receives its word at position `SECTOR_WORDS+MAX_OVR` without a sync, a forced start is reported with class long (2) and cause 6. The position counter never goes above `SECTOR_WORDS+MAX_OVR`.
- R8: A misplaced sync that is accepted inside a sector opened by an interpolated or forced start reports cause 5 instead of cause 3.
- R9: `irq` and `irq_cause` stay set until a cycle in which `irq_ack` is 1, which clears both to 0. If a new event occurs in the same cycle as the acknowledge, the event wins. A new event always overwrites the cause. `irq_cause` is nonzero exactly when `irq` is 1.
- R10: `resync_mode` and `stretch_mode` are sampled only on the word that starts a sector. A change made in the middle of a sector has no effect until the next start.
- R11: Outputs are registered and change one clock after the word that causes them. A cycle with `word_vld` at 0 is ignored, including any `sync_det` in that cycle. `sector_class` changes only together with a `sector_start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_vld | input | 1 | A stream word is present this cycle |
| sync_det | input | 1 | The present word carries a sync pattern |
| resync_mode | input | 1 | Misplaced-sync policy: 0 discard, 1 restart framing |
| stretch_mode | input | 1 | Missing-sync policy: 0 interpolate, 1 stretch sector |
| irq_ack | input | 1 | Write-one-to-clear for the interrupt and its cause |
| sector_start | output | 1 | One-cycle pulse marking the start of a sector |
| sector_class | output | 2 | Length class of the sector just ended: 0 normal, 1 short, 2 long |
| irq | output | 1 | Sticky sync-irregularity interrupt |
| irq_cause | output | 3 | Cause of the latest irregular event (1 to 6) |

## Verification
The bench builds the block with `SECTOR_WORDS` set to 8 and `MAX_OVR` set to 3. With these values a full sector, a misplaced sync, a stretched sector and a forced cutoff each take only a dozen words. That makes every policy combination reachable in one short run, including an interpolated sector followed by a resync and an acknowledge that coincides with an event. The small overrun bound also lets the counter's upper limit be reached and checked directly.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_SHORT  = 2'd1,
    CLS_LONG   = 2'd2
  } ssg_cls_e;

  typedef enum logic [2:0] {
    CAU_NONE    = 3'd0,
    CAU_IGNORED = 3'd1,
    CAU_INTERP  = 3'd2,
    CAU_RESYNC  = 3'd3,
    CAU_PROLONG = 3'd4,
    CAU_SHORT   = 3'd5,
    CAU_LONG    = 3'd6
  } ssg_cause_e;

  typedef struct packed {
    logic       start;
    ssg_cls_e   cls;
    ssg_cause_e cause;
    logic       interp;
  } ssg_dec_t;

  // Decision for one qualified word while framing is locked.
  function automatic ssg_dec_t ssg_decide(
    input logic        sync,
    input int unsigned pos,
    input int unsigned term,
    input int unsigned lim,
    input logic        pol_resync,
    input logic        pol_stretch,
    input logic        in_interp
  );
    ssg_dec_t d;
    d = '0;
    if (sync) begin
      if (pos >= term) begin
        d.start = 1'b1;
        d.cls   = (pos == term) ? CLS_NORMAL : CLS_LONG;
      end else if (pol_resync) begin
        d.start = 1'b1;
        d.cls   = CLS_SHORT;
        d.cause = in_interp ? CAU_SHORT : CAU_RESYNC;
      end else begin
        d.cause = CAU_IGNORED;
      end
    end else if (pos == term) begin
      if (pol_stretch) begin
        d.cause = CAU_PROLONG;
      end else begin
        d.start  = 1'b1;
        d.cls    = CLS_NORMAL;
        d.cause  = CAU_INTERP;
        d.interp = 1'b1;
      end
    end else if (pos >= lim) begin
      d.start  = 1'b1;
      d.cls    = CLS_LONG;
      d.cause  = CAU_LONG;
      d.interp = 1'b1;
    end
    return d;
  endfunction

endpackage

// File: rtl/ssg_frame_track.sv
module ssg_frame_track
  import ssg_pkg::*;
#(
  parameter int TERM  = 2352,
  parameter int LIM   = 2416,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_vld,
  input  logic             sync_det,
  input  logic             resync_mode,
  input  logic             stretch_mode,
  output ssg_dec_t         evt,
  output logic [CNT_W-1:0] cnt_q
);

  logic locked_q;
  logic pol_res_q;
  logic pol_str_q;
  logic interp_q;

  always_comb begin
    evt = '0;
    if (word_vld) begin
      if (!locked_q) begin
        evt.start = sync_det;
      end else begin
        evt = ssg_decide(sync_det, 32'(cnt_q), TERM, LIM,
                         pol_res_q, pol_str_q, interp_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      locked_q  <= 1'b0;
      pol_res_q <= 1'b0;
      pol_str_q <= 1'b0;
      interp_q  <= 1'b0;
    end else if (evt.start) begin
      cnt_q     <= CNT_W'(1);
      locked_q  <= 1'b1;
      pol_res_q <= resync_mode;
      pol_str_q <= stretch_mode;
      interp_q  <= evt.interp;
    end else if (word_vld && locked_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ssg_irq_hold.sv
module ssg_irq_hold
  import ssg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ssg_cause_e evt_cause,
  input  logic       irq_ack,
  output logic       irq,
  output logic [2:0] irq_cause
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq       <= 1'b0;
      irq_cause <= 3'd0;
    end else if (evt_cause != CAU_NONE) begin
      irq       <= 1'b1;
      irq_cause <= evt_cause;
    end else if (irq_ack) begin
      irq       <= 1'b0;
      irq_cause <= 3'd0;
    end
  end

endmodule

// File: rtl/sector_sync_guard.sv
module sector_sync_guard
  import ssg_pkg::*;
#(
  parameter int SECTOR_WORDS = 2352,
  parameter int MAX_OVR      = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_vld,
  input  logic       sync_det,
  input  logic       resync_mode,
  input  logic       stretch_mode,
  input  logic       irq_ack,
  output logic       sector_start,
  output logic [1:0] sector_class,
  output logic       irq,
  output logic [2:0] irq_cause
);

  localparam int LIM   = SECTOR_WORDS + MAX_OVR;
  localparam int CNT_W = $clog2(LIM + 1);

  ssg_dec_t         evt;
  logic [CNT_W-1:0] frame_cnt;

  ssg_frame_track #(
    .TERM (SECTOR_WORDS),
    .LIM  (LIM),
    .CNT_W(CNT_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_vld    (word_vld),
    .sync_det    (sync_det),
    .resync_mode (resync_mode),
    .stretch_mode(stretch_mode),
    .evt         (evt),
    .cnt_q       (frame_cnt)
  );

  ssg_irq_hold u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_cause(evt.cause),
    .irq_ack  (irq_ack),
    .irq      (irq),
    .irq_cause(irq_cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_start <= 1'b0;
      sector_class <= 2'd0;
    end else begin
      sector_start <= evt.start;
      if (evt.start) sector_class <= evt.cls;
    end
  end

endmodule

// File: rtl/ssg_checker.sv
module ssg_checker #(
  parameter int LIM   = 2416,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_vld,
  input logic             sync_det,
  input logic             irq_ack,
  input logic             sector_start,
  input logic [1:0]       sector_class,
  input logic             irq,
  input logic [2:0]       irq_cause,
  input logic [CNT_W-1:0] frame_cnt
);

  AST_START_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    sector_start |-> $past(word_vld)); // R11

  AST_CLASS_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !sector_start |-> $stable(sector_class)); // R11

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R9

  AST_CAUSE_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_cause != 3'd0)); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_cnt) <= LIM); // R7

  AST_SHORT_FROM_REAL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_start && sector_class == 2'd1) |-> $past(sync_det)); // R4

endmodule

bind sector_sync_guard ssg_checker #(.LIM(LIM), .CNT_W(CNT_W)) u_ssg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_vld    (word_vld),
  .sync_det    (sync_det),
  .irq_ack     (irq_ack),
  .sector_start(sector_start),
  .sector_class(sector_class),
  .irq         (irq),
  .irq_cause   (irq_cause),
  .frame_cnt   (frame_cnt)
);

// File: tb/test_sector_sync_guard.sv
module test_sector_sync_guard;

  localparam int CLK_PERIOD = 10;
  localparam int TERM       = 8;
  localparam int OVR        = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_vld = 1'b0;
  logic       sync_det = 1'b0;
  logic       resync_mode = 1'b0;
  logic       stretch_mode = 1'b0;
  logic       irq_ack = 1'b0;
  logic       sector_start;
  logic [1:0] sector_class;
  logic       irq;
  logic [2:0] irq_cause;

  sector_sync_guard #(.SECTOR_WORDS(TERM), .MAX_OVR(OVR)) i_sector_sync_guard (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .sync_det(sync_det),
    .resync_mode(resync_mode), .stretch_mode(stretch_mode), .irq_ack(irq_ack),
    .sector_start(sector_start), .sector_class(sector_class),
    .irq(irq), .irq_cause(irq_cause)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic       st;
    logic [1:0] cls;
    logic       irq;
    logic [2:0] cause;
    int         due;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // reference state of the bench
  bit         m_locked = 0;
  int         m_pos = 0;
  bit         m_res = 0, m_str = 0, m_interp = 0;
  logic [1:0] m_cls = 0;
  logic       m_irq = 0;
  logic [2:0] m_cause = 0;
  bit         drv_res = 0, drv_str = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare due items
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sector_start !== e.st || sector_class !== e.cls ||
          irq !== e.irq || irq_cause !== e.cause) begin
        fails++;
        $display("FAIL %s: got start=%0b class=%0d irq=%0b cause=%0d, expected start=%0b class=%0d irq=%0b cause=%0d",
                 e.req, sector_start, sector_class, irq, irq_cause,
                 e.st, e.cls, e.irq, e.cause);
      end
    end
  end

  task automatic drive(input logic vld, input logic sync, input logic ack, input string req);
    logic       st;
    logic [2:0] ev;
    logic [1:0] cl;
    exp_t       e;
    @(negedge clk);
    word_vld = vld; sync_det = sync; irq_ack = ack;
    resync_mode = drv_res; stretch_mode = drv_str;
    st = 0; ev = 0; cl = m_cls;
    if (vld) begin
      if (!m_locked) begin
        if (sync) begin st = 1; cl = 0; end
      end else if (sync && m_pos == TERM) begin
        st = 1; cl = 0;
      end else if (sync && m_pos > TERM) begin
        st = 1; cl = 2;
      end else if (sync) begin
        if (m_res) begin st = 1; cl = 1; ev = m_interp ? 3'd5 : 3'd3; end
        else ev = 3'd1;
      end else if (m_pos == TERM) begin
        if (m_str) ev = 3'd4;
        else begin st = 1; cl = 0; ev = 3'd2; end
      end else if (m_pos == TERM + OVR) begin
        st = 1; cl = 2; ev = 3'd6;
      end
    end
    if (st) begin
      m_locked = 1; m_pos = 1; m_res = drv_res; m_str = drv_str;
      m_interp = (ev == 3'd2 || ev == 3'd6);
      m_cls = cl;
    end else if (vld && m_locked) begin
      m_pos++;
    end
    if (ev != 0) begin m_irq = 1; m_cause = ev; end
    else if (ack) begin m_irq = 0; m_cause = 0; end
    e.st = st; e.cls = m_cls; e.irq = m_irq; e.cause = m_cause;
    e.due = cyc + 1; e.req = req;
    q.push_back(e);
  endtask

  task automatic plain(input int n, input string req);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 0, "R1");            // reset state
    drive(1, 0, 0, "R1");            // unlocked, no sync
    drive(1, 0, 0, "R1");
    drive(0, 1, 0, "R11");           // sync without valid ignored
    drive(1, 1, 0, "R1");            // lock
    plain(7, "R2");
    drive(1, 1, 0, "R2");            // normal start
    plain(2, "R3");
    drive(1, 1, 0, "R3");            // ignored, cause 1
    plain(4, "R3");
    drive(1, 1, 0, "R2");            // framing kept
    drive(0, 0, 0, "R9");            // still pending
    drive(0, 0, 1, "R9");            // acknowledge
    drv_res = 1;                     // mid-sector change
    plain(2, "R10");
    drive(1, 1, 0, "R10");           // still discarded
    plain(4, "R10");
    drive(1, 1, 0, "R2");            // loads resync policy
    drive(0, 0, 1, "R9");
    plain(2, "R4");
    drive(1, 1, 0, "R4");            // resync, short, cause 3
    plain(7, "R5");
    drive(1, 0, 0, "R5");            // interpolated, cause 2
    plain(2, "R8");
    drive(1, 1, 0, "R8");            // resync in interp sector, cause 5
    drv_str = 1;
    plain(7, "R2");
    drive(1, 1, 0, "R2");            // loads stretch policy
    plain(7, "R6");
    drive(1, 0, 0, "R6");            // prolong, cause 4
    drive(1, 0, 0, "R6");
    drive(1, 1, 0, "R6");            // late sync, long
    drive(0, 0, 1, "R9");
    plain(7, "R7");
    drive(1, 0, 0, "R7");            // prolong
    drive(1, 0, 0, "R7");
    drive(1, 0, 0, "R7");
    drive(1, 0, 0, "R7");            // forced end, long, cause 6
    plain(7, "R9");
    drive(1, 0, 1, "R9");            // event beats acknowledge
    drive(0, 0, 1, "R9");            // clear
    drive(1, 1, 0, "R11");
    drive(0, 0, 0, "R11");
    drive(0, 0, 0, "R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary();
    end
  end

endmodule